// File: doc/BRIEF.md
# Supervisory Reset Generator with Watchdog

This block produces an active-low processor reset and a matching interface-disable gate. Three causes can raise reset: a manual push-button line (active low), a digital supply-undervoltage flag from an external comparator (active high), and a watchdog that expects edges on its strobe input while enabled. The manual and supply inputs pass through a two-flop synchronizer and then a glitch filter. The filter only accepts a level that holds for a set number of clock samples, so short pulses and brief supply dips are rejected.

All causes feed one shared stretch timer. Reset is held while any cause is present. After the last cause clears, reset stays asserted for a fixed number of clock cycles, and a cause that returns during this time restarts the count from zero. An asynchronous power-on clear forces reset on power-up. Reset then releases only after the supply flag is clear and the stretch time has passed. While reset is active, the gate output disables the chip's serial interface inputs (chip-enable pass-through, data-in, chip-select, serial clock) and its data output. The watchdog counter is also held cleared, so it starts a full window when reset releases. All times are parameters counted in system clock cycles. The block has no streaming data path, so every pin is plain control or status with no valid/ready handshake.

Top module: `sup_reset_gen`

## Requirements
- R1: While `por_n` is low, `rst_n` is 0. After `por_n` rises with `supply_low` at 0, `rst_n` stays 0 for RST_TO cycles and then goes to 1.
- R2: Holding `mr_n` at 0 for at least MR_FILT clock samples (after the 2-cycle synchronizer) drives `rst_n` to 0. Reset stays 0 for as long as `mr_n` is held low.
- R3: A low pulse on `mr_n` shorter than MR_FILT samples leaves `rst_n` at 1.
- R4: Once the filtered manual cause clears, `rst_n` returns to 1 exactly RST_TO cycles later, unless another cause appears in that time.
- R5: A `supply_low` pulse shorter than SV_FILT samples leaves `rst_n` at 1. A pulse of SV_FILT samples or more drives `rst_n` to 0.
- R6: When the filtered supply cause clears, `rst_n` returns to 1 exactly RST_TO cycles later.
- R7: With `wd_en` at 1 and reset inactive, WD_TO consecutive cycles without a change on the synchronized `wdi` produce a reset that lasts RST_TO cycles.
- R8: Any change on `wdi` restarts the watchdog window. With `wd_en` at 0 the watchdog never raises reset. The window is held cleared while reset is active, so it restarts from zero when reset releases.
- R9: A cause that appears while the stretch count is running restarts the count from zero.
- R10: `io_block` is 1 in exactly the cycles where `rst_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| mr_n | input | 1 | Raw manual-reset line, active low, asynchronous |
| supply_low | input | 1 | Undervoltage comparator output, 1 = supply below threshold |
| wdi | input | 1 | Watchdog strobe; any edge counts as a service |
| wd_en | input | 1 | 1 enables the watchdog |
| rst_n | output | 1 | Processor reset, active low |
| io_block | output | 1 | 1 = interface inputs and data output disabled |

## Verification
Several properties are checked on every cycle. The filters may only raise their output after a full run of active samples. The stretch counter stays in range and can only release after a complete quiet count with no cause present. The watchdog bites only while enabled and out of reset, and a strobe edge clears its window. Some behaviours can only be shown by the bench scenarios, where a cycle-level reference model is compared on every clock: the exact release cycle after each cause clears, rejection of short manual and supply pulses, restart of the count when a new cause appears mid-stretch, and a watchdog that stays quiet while disabled or while it is being serviced.

// File: rtl/srg_pkg.sv
package srg_pkg;
  typedef struct packed {
    logic manual;
    logic supply;
    logic dog;
  } srg_cause_t;

  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/srg_sync.sv
module srg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic por_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srg_filter.sv
module srg_filter #(
  parameter int FLEN = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic act,
  output logic held
);
  localparam int CW = srg_pkg::cnt_width(FLEN);
  localparam logic [CW-1:0] LAST = CW'(FLEN - 1);

  logic [CW-1:0] run;
  logic          held_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      run    <= '0;
      held_q <= 1'b0;
    end else if (!act) begin
      run    <= '0;
      held_q <= 1'b0;
    end else if (run == LAST) begin
      held_q <= 1'b1;
    end else begin
      run <= run + CW'(1);
    end
  end

  assign held = held_q;

  // R3 / R5: output only rises after a full run of active samples
  p_filter_len_r3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(held_q) |-> ($past(run) == LAST) && $past(act));

  // R3: an inactive sample drops the filtered level next cycle
  p_filter_drop_r3: assert property (@(posedge clk) disable iff (!por_n)
    !act |=> !held_q);
endmodule

// File: rtl/srg_watchdog.sv
module srg_watchdog #(
  parameter int WD_TO = 40
) (
  input  logic clk,
  input  logic por_n,
  input  logic strobe,
  input  logic enable,
  input  logic hold,
  output logic bite
);
  localparam int CW = srg_pkg::cnt_width(WD_TO);
  localparam logic [CW-1:0] LAST = CW'(WD_TO - 1);

  logic          prev;
  logic [CW-1:0] quiet;
  logic          bite_q;
  logic          serviced;

  assign serviced = (strobe != prev);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      prev   <= 1'b0;
      quiet  <= '0;
      bite_q <= 1'b0;
    end else begin
      prev <= strobe;
      if (hold || !enable || serviced) begin
        quiet  <= '0;
        bite_q <= 1'b0;
      end else if (quiet == LAST) begin
        quiet  <= '0;
        bite_q <= 1'b1;
      end else begin
        quiet  <= quiet + CW'(1);
        bite_q <= 1'b0;
      end
    end
  end

  assign bite = bite_q;

  // R7: a bite only comes from an enabled watchdog outside reset
  p_bite_enabled_r7: assert property (@(posedge clk) disable iff (!por_n)
    bite_q |-> $past(enable) && !$past(hold));

  // R8: a strobe edge restarts the window
  p_edge_clears_r8: assert property (@(posedge clk) disable iff (!por_n)
    serviced |=> (quiet == '0) && !bite_q);

  // R8: window counter never leaves its range
  p_quiet_bound_r8: assert property (@(posedge clk) disable iff (!por_n)
    quiet <= LAST);
endmodule

// File: rtl/srg_stretch.sv
module srg_stretch #(
  parameter int RST_TO = 20
) (
  input  logic clk,
  input  logic por_n,
  input  logic cause,
  output logic active
);
  localparam int CW = srg_pkg::cnt_width(RST_TO);
  localparam logic [CW-1:0] LAST = CW'(RST_TO - 1);

  logic          act_q;
  logic [CW-1:0] tcnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      act_q <= 1'b1;
      tcnt  <= '0;
    end else if (cause) begin
      act_q <= 1'b1;
      tcnt  <= '0;
    end else if (act_q) begin
      if (tcnt == LAST) begin
        act_q <= 1'b0;
        tcnt  <= '0;
      end else begin
        tcnt <= tcnt + CW'(1);
      end
    end
  end

  assign active = act_q;

  // R9: any cause forces reset and restarts the count from zero
  p_cause_restart_r9: assert property (@(posedge clk) disable iff (!por_n)
    cause |=> act_q && (tcnt == '0));

  // R4 / R6: release only after a full quiet count with no cause
  p_release_r4: assert property (@(posedge clk) disable iff (!por_n)
    $fell(act_q) |-> ($past(tcnt) == LAST) && !$past(cause));

  // R9: count stays in range
  p_tcnt_bound_r9: assert property (@(posedge clk) disable iff (!por_n)
    tcnt <= LAST);
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter int SYNC_STAGES = 2,
  parameter int MR_FILT     = 125,
  parameter int SV_FILT     = 6500,
  parameter int WD_TO       = 200_000_000,
  parameter int RST_TO      = 17_500_000
) (
  input  logic clk,
  input  logic por_n,
  input  logic mr_n,
  input  logic supply_low,
  input  logic wdi,
  input  logic wd_en,
  output logic rst_n,
  output logic io_block
);
  import srg_pkg::*;

  logic       mr_s, sv_s, wdi_s;
  logic       mr_held, sv_held, dog_bite;
  logic       rst_act;
  srg_cause_t causes;

  srg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_mr (
    .clk(clk), .por_n(por_n), .d(mr_n), .q(mr_s));
  srg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sv (
    .clk(clk), .por_n(por_n), .d(supply_low), .q(sv_s));
  srg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_wd (
    .clk(clk), .por_n(por_n), .d(wdi), .q(wdi_s));

  srg_filter #(.FLEN(MR_FILT)) u_filt_mr (
    .clk(clk), .por_n(por_n), .act(!mr_s), .held(mr_held));
  srg_filter #(.FLEN(SV_FILT)) u_filt_sv (
    .clk(clk), .por_n(por_n), .act(sv_s), .held(sv_held));

  srg_watchdog #(.WD_TO(WD_TO)) u_dog (
    .clk(clk), .por_n(por_n), .strobe(wdi_s), .enable(wd_en),
    .hold(rst_act), .bite(dog_bite));

  assign causes.manual = mr_held;
  assign causes.supply = sv_held;
  assign causes.dog    = dog_bite;

  srg_stretch #(.RST_TO(RST_TO)) u_stretch (
    .clk(clk), .por_n(por_n), .cause(|causes), .active(rst_act));

  assign rst_n    = !rst_act;
  assign io_block = rst_act;

  // R2: an accepted manual press holds reset low on the next cycle
  p_manual_forces_r2: assert property (@(posedge clk) disable iff (!por_n)
    mr_held |=> !rst_n);

  // R5: an accepted supply-low level holds reset low on the next cycle
  p_supply_forces_r5: assert property (@(posedge clk) disable iff (!por_n)
    sv_held |=> !rst_n);
endmodule

// File: tb/sup_reset_gen_bench.sv
module sup_reset_gen_bench;
  localparam int MRF = 8;
  localparam int SVF = 6;
  localparam int WDT = 40;
  localparam int RTO = 20;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic mr_n = 1'b1;
  logic supply_low = 1'b0;
  logic wdi = 1'b0;
  logic wd_en = 1'b0;
  logic rst_n, io_block;

  int compared = 0;
  int mismatched = 0;
  string cur = "R1";

  always #4 clk = ~clk;

  sup_reset_gen #(.SYNC_STAGES(2), .MR_FILT(MRF), .SV_FILT(SVF),
                  .WD_TO(WDT), .RST_TO(RTO)) u_sup_reset_gen (
    .clk(clk), .por_n(por_n), .mr_n(mr_n), .supply_low(supply_low),
    .wdi(wdi), .wd_en(wd_en), .rst_n(rst_n), .io_block(io_block));

  // behavioural reference: delay lines, run lengths, idle counts
  int m_mr[2] = '{1, 1};
  int m_sv[2] = '{0, 0};
  int m_wd[2] = '{0, 0};
  int m_wlast = 0;
  int m_mrrun = 0, m_svrun = 0;
  int m_mrf = 0, m_svf = 0;
  int m_quiet = 0, m_bite = 0;
  int m_act = 1, m_idle = 0;

  always @(posedge clk) begin
    if (!por_n) begin
      m_mr = '{1, 1}; m_sv = '{0, 0}; m_wd = '{0, 0}; m_wlast = 0;
      m_mrrun = 0; m_svrun = 0; m_mrf = 0; m_svf = 0;
      m_quiet = 0; m_bite = 0; m_act = 1; m_idle = 0;
    end else begin
      int cause_old, act_old, edge_seen;
      cause_old = m_mrf | m_svf | m_bite;
      act_old   = m_act;
      edge_seen = (m_wd[1] != m_wlast);
      m_wlast   = m_wd[1];
      if (act_old != 0 || !wd_en || edge_seen != 0) begin
        m_quiet = 0; m_bite = 0;
      end else begin
        m_quiet = m_quiet + 1;
        m_bite  = (m_quiet == WDT);
        if (m_bite != 0) m_quiet = 0;
      end
      if (cause_old != 0) begin
        m_act = 1; m_idle = 0;
      end else if (m_act != 0) begin
        m_idle = m_idle + 1;
        if (m_idle == RTO) begin m_act = 0; m_idle = 0; end
      end
      m_mrrun = (m_mr[1] == 0) ? m_mrrun + 1 : 0;
      m_mrf   = (m_mrrun >= MRF);
      m_svrun = (m_sv[1] != 0) ? m_svrun + 1 : 0;
      m_svf   = (m_svrun >= SVF);
      m_mr[1] = m_mr[0]; m_mr[0] = mr_n;
      m_sv[1] = m_sv[0]; m_sv[0] = supply_low;
      m_wd[1] = m_wd[0]; m_wd[0] = wdi;
    end
  end

  // cycle compare against the model, away from the active edge
  always @(negedge clk) begin
    compared++;
    if (rst_n !== (m_act == 0) || io_block !== (m_act != 0)) begin
      mismatched++;
      $display("FAIL %s/R10 cycle compare: rst_n=%b io_block=%b expected rst_n=%b io_block=%b",
               cur, rst_n, io_block, m_act == 0, m_act != 0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic point(input string req, input logic got, input logic exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s point check: rst_n=%b expected %b", req, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1 power-up
    cur = "R1";
    cyc(5);
    point("R1", rst_n, 1'b0);
    por_n = 1'b1;
    cyc(10);
    point("R1", rst_n, 1'b0);
    cyc(20);
    point("R1", rst_n, 1'b1);

    // R3 short manual pulse ignored
    cur = "R3";
    mr_n = 1'b0; cyc(4); mr_n = 1'b1;
    cyc(30);
    point("R3", rst_n, 1'b1);

    // R2 / R4 long manual press and release
    cur = "R2";
    mr_n = 1'b0; cyc(20);
    point("R2", rst_n, 1'b0);
    cyc(20);
    point("R2", rst_n, 1'b0);
    cur = "R4";
    mr_n = 1'b1; cyc(15);
    point("R4", rst_n, 1'b0);
    cyc(20);
    point("R4", rst_n, 1'b1);

    // R5 / R6 supply dips
    cur = "R5";
    supply_low = 1'b1; cyc(3); supply_low = 1'b0;
    cyc(30);
    point("R5", rst_n, 1'b1);
    supply_low = 1'b1; cyc(15);
    point("R5", rst_n, 1'b0);
    cur = "R6";
    supply_low = 1'b0; cyc(12);
    point("R6", rst_n, 1'b0);
    cyc(20);
    point("R6", rst_n, 1'b1);

    // R8 serviced watchdog stays quiet
    cur = "R8";
    wd_en = 1'b1;
    for (int i = 0; i < 15; i++) begin
      wdi = ~wdi; cyc(10);
      point("R8", rst_n, 1'b1);
    end

    // R7 starved watchdog bites
    cur = "R7";
    begin
      bit seen_low;
      seen_low = 1'b0;
      for (int i = 0; i < 80; i++) begin
        cyc(1);
        if (rst_n === 1'b0) seen_low = 1'b1;
      end
      point("R7", seen_low ? 1'b0 : 1'b1, 1'b0);
    end

    // R8 disabled watchdog never bites
    cur = "R8";
    wd_en = 1'b0; cyc(30);
    begin
      bit seen_low;
      seen_low = 1'b0;
      for (int i = 0; i < 100; i++) begin
        cyc(1);
        if (rst_n === 1'b0) seen_low = 1'b1;
      end
      point("R8", seen_low ? 1'b0 : 1'b1, 1'b1);
    end

    // R9 new cause mid-stretch restarts the count
    cur = "R9";
    mr_n = 1'b0; cyc(15); mr_n = 1'b1;
    cyc(10);
    supply_low = 1'b1; cyc(8); supply_low = 1'b0;
    cyc(14);
    point("R9", rst_n, 1'b0);
    cyc(25);
    point("R9", rst_n, 1'b1);

    cyc(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule